// File: doc/BRIEF.md
# Threshold-Signalling Data FIFO

This block is a circular word buffer placed between a processor data port and a card-side byte engine. It moves data in one direction at a time. With the direction input set to receive, the card side fills the buffer and the processor drains it. With it set to transmit, the processor fills the buffer and the card side drains it. Strobes from the side that is not active in the current direction are ignored.

Two programmable thresholds watch the fill level. In receive, the watched condition is the level rising above the almost-full threshold. In transmit, it is the level dropping below the almost-empty threshold. A per-direction DMA-enable bit decides what happens when the condition holds. If DMA is enabled, the block raises that direction's DMA request. If DMA is disabled, it raises that direction's status flag instead. The two are never raised together. The threshold outputs are combinational functions of the registered fill level and the registered configuration.

A processor write to a full buffer is dropped. A processor read from an empty buffer leaves the buffer untouched, returns whatever word sits at the read position, and produces a one-cycle underrun pulse.

Top module: `dma_fifo_buffer`

## Requirements
- R1: After reset the buffer is empty. The almost-full threshold is 31, the almost-empty threshold is 0, and both DMA-enable bits are clear. No request, flag or underrun output is high.
- R2: Words leave the buffer in the order they entered. Storage is addressed circularly: the write slot is (read position + level) modulo 32, and the read position advances by one, wrapping, on every accepted pop. The read data ports show the word at the read position while the pop strobe is high.
- R3: With the direction input high (receive), only the card push and processor read strobes act. With it low (transmit), only the processor write and card pop strobes act. The other two strobes change neither the level, nor the stored words, nor the underrun output.
- R4: A push while 32 words are held is discarded. This holds even when a pop is accepted in the same cycle.
- R5: In receive, a processor read while the buffer is empty leaves the level and the read position unchanged. The read data port shows the word at the read position. The underrun output is high for exactly the one cycle after that clock edge. A card pop on an empty buffer is ignored.
- R6: In receive, when the level exceeds the almost-full threshold, the receive DMA request is high and the almost-full flag is low if receive DMA is enabled. If receive DMA is disabled, the flag is high and the request is low.
- R7: In transmit, when the level is below the almost-empty threshold, the transmit DMA request is high and the almost-empty flag is low if transmit DMA is enabled. If transmit DMA is disabled, the flag is high and the request is low.
- R8: When the condition for a direction does not hold, that direction's request and flag are both low. The condition includes the direction input, so the receive outputs are low in transmit and the transmit outputs are low in receive.
- R9: While the transfer-active input is low and the buffer is empty, both flags are low. DMA requests still follow R6 and R7.
- R10: A configuration load strobe captures both thresholds and both DMA-enable bits at the clock edge. Values on the configuration inputs have no effect without that strobe.
- R11: An accepted push and an accepted pop in the same cycle leave the level unchanged, and both are served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dirRx | input | 1 | 1 = receive (card fills, processor drains), 0 = transmit |
| xferActive | input | 1 | A transfer is in progress |
| cpuWrEn | input | 1 | Processor push strobe (transmit) |
| cpuWrData | input | WIDTH | Processor push word |
| cpuRdEn | input | 1 | Processor pop strobe (receive) |
| cpuRdData | output | WIDTH | Word at the read position |
| underrunPulse | output | 1 | One-cycle pulse after a processor read from an empty buffer |
| cardPushEn | input | 1 | Card-side push strobe (receive) |
| cardPushData | input | WIDTH | Card-side push word |
| cardPopEn | input | 1 | Card-side pop strobe (transmit) |
| cardPopData | output | WIDTH | Word at the read position |
| cfgWr | input | 1 | Configuration load strobe |
| cfgAfLevel | input | THR_W | Almost-full threshold to load |
| cfgAeLevel | input | THR_W | Almost-empty threshold to load |
| cfgRxDmaEn | input | 1 | Receive DMA enable to load |
| cfgTxDmaEn | input | 1 | Transmit DMA enable to load |
| rxDmaReq | output | 1 | Receive DMA request |
| txDmaReq | output | 1 | Transmit DMA request |
| afFlag | output | 1 | Almost-full status flag |
| aeFlag | output | 1 | Almost-empty status flag |

## Verification
The bench uses the default parameters: DEPTH 32, WIDTH 16 and THR_W 5. At that size it can run every threshold value from 0 to 31 in both directions and both DMA modes, and at each setting walk the level through every value from 0 to 32 and back. That way each compare is checked on both sides of its boundary, including the overfull push and the empty read. Each pass first moves the read position by one slot, so pointer wrap-around is covered across the sweep. Directed sequences then cover ignored strobes, simultaneous push and pop at full, underrun pulse length, idle flag clearing and configuration load timing.

// File: rtl/dma_fifo_pkg.sv
package dma_fifo_pkg;

  // Strobes the control side hands to the storage datapath each cycle.
  typedef struct packed {
    logic push;          // accepted push this cycle
    logic pop;           // accepted pop this cycle
    logic pushFromCard;  // push word taken from the card side
  } fifoStrobe_t;

endpackage

// File: rtl/dma_fifo_dp.sv
module dma_fifo_dp
  import dma_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strb,
  input  logic [WIDTH-1:0]  cpuWrData,
  input  logic [WIDTH-1:0]  cardPushData,
  output logic [WIDTH-1:0]  headData,
  output logic [CNT_W-1:0]  level
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] startPtr;
  logic [CNT_W-1:0] lenCnt;
  logic [PTR_W-1:0] wrAddr;
  logic [PTR_W-1:0] startNext;
  logic [WIDTH-1:0] pushWord;

  // Write slot = (start + length) mod DEPTH; variant picked by depth shape.
  generate
    if ((1 << PTR_W) == DEPTH) begin : g_pow2Wrap
      assign wrAddr = startPtr + lenCnt[PTR_W-1:0];
    end else begin : g_modWrap
      logic [CNT_W:0] addrSum;
      assign addrSum = {2'b00, startPtr} + {1'b0, lenCnt};
      assign wrAddr  = (addrSum >= (CNT_W+1)'(DEPTH))
                     ? PTR_W'(addrSum - (CNT_W+1)'(DEPTH))
                     : PTR_W'(addrSum);
    end
  endgenerate

  assign startNext = (startPtr == PTR_W'(DEPTH - 1)) ? '0 : startPtr + 1'b1;
  assign pushWord  = strb.pushFromCard ? cardPushData : cpuWrData;

  always_ff @(posedge clk) begin
    if (strb.push) begin
      mem[wrAddr] <= pushWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startPtr <= '0;
      lenCnt   <= '0;
    end else begin
      if (strb.pop) begin
        startPtr <= startNext;
      end
      case ({strb.push, strb.pop})
        2'b10:   lenCnt <= lenCnt + 1'b1;
        2'b01:   lenCnt <= lenCnt - 1'b1;
        default: lenCnt <= lenCnt;
      endcase
    end
  end

  assign headData = mem[startPtr];
  assign level    = lenCnt;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> (lenCnt < CNT_W'(DEPTH))) else $error("push into full storage"); // R4

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> (lenCnt != '0)) else $error("pop from empty storage"); // R5

  AST_PUSHPOP_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && strb.pop) |=> $stable(lenCnt)) else $error("level moved on push+pop"); // R11

  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (lenCnt == '0 && !strb.push) |=> (lenCnt == '0 && $stable(startPtr))) else $error("empty storage moved"); // R5

endmodule

// File: rtl/dma_fifo_ctrl.sv
module dma_fifo_ctrl
  import dma_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int THR_W = 5,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dirRx,
  input  logic              xferActive,
  input  logic              cpuWrEn,
  input  logic              cpuRdEn,
  input  logic              cardPushEn,
  input  logic              cardPopEn,
  input  logic              cfgWr,
  input  logic [THR_W-1:0]  cfgAfLevel,
  input  logic [THR_W-1:0]  cfgAeLevel,
  input  logic              cfgRxDmaEn,
  input  logic              cfgTxDmaEn,
  input  logic [CNT_W-1:0]  level,
  output fifoStrobe_t       strb,
  output logic              underrunPulse,
  output logic              rxDmaReq,
  output logic              txDmaReq,
  output logic              afFlag,
  output logic              aeFlag
);

  localparam logic [THR_W-1:0] AF_RESET = '1;
  localparam logic [THR_W-1:0] AE_RESET = '0;

  logic [THR_W-1:0] afLvl;
  logic [THR_W-1:0] aeLvl;
  logic             rxDmaOn;
  logic             txDmaOn;
  logic             producerPush;
  logic             consumerPop;
  logic             isFull;
  logic             isEmpty;
  logic             rxHit;
  logic             txHit;
  logic             idleEmpty;

  // Direction steering: receive = card produces, processor consumes.
  assign producerPush = dirRx ? cardPushEn : cpuWrEn;
  assign consumerPop  = dirRx ? cpuRdEn    : cardPopEn;
  assign isFull       = (level == CNT_W'(DEPTH));
  assign isEmpty      = (level == '0);

  always_comb begin
    strb              = '0;
    strb.push         = producerPush && !isFull;
    strb.pop          = consumerPop && !isEmpty;
    strb.pushFromCard = dirRx;
  end

  // Configuration registers.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      afLvl   <= AF_RESET;
      aeLvl   <= AE_RESET;
      rxDmaOn <= 1'b0;
      txDmaOn <= 1'b0;
    end else if (cfgWr) begin
      afLvl   <= cfgAfLevel;
      aeLvl   <= cfgAeLevel;
      rxDmaOn <= cfgRxDmaEn;
      txDmaOn <= cfgTxDmaEn;
    end
  end

  // Underrun: processor read against empty storage in receive.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      underrunPulse <= 1'b0;
    end else begin
      underrunPulse <= dirRx && cpuRdEn && isEmpty;
    end
  end

  // Threshold evaluation from registered level and configuration.
  assign rxHit     = dirRx  && (level > CNT_W'(afLvl));
  assign txHit     = !dirRx && (level < CNT_W'(aeLvl));
  assign idleEmpty = !xferActive && isEmpty;

  assign rxDmaReq = rxHit && rxDmaOn;
  assign txDmaReq = txHit && txDmaOn;
  assign afFlag   = rxHit && !rxDmaOn && !idleEmpty;
  assign aeFlag   = txHit && !txDmaOn && !idleEmpty;

  AST_IDLE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (!xferActive && level == '0) |-> (!afFlag && !aeFlag)) else $error("flag while idle and empty"); // R9

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWr |=> ($stable(afLvl) && $stable(aeLvl) && $stable(rxDmaOn) && $stable(txDmaOn)))
    else $error("configuration changed without load"); // R10

  AST_UNDERRUN_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    underrunPulse |-> ($past(level) == '0)) else $error("underrun with data held"); // R5

  AST_RX_IGNORES_CPU_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (dirRx && !cardPushEn) |=> $stable(level) || ($past(level) != '0 && $past(cpuRdEn)))
    else $error("level grew without card push in receive"); // R3

endmodule

// File: rtl/dma_fifo_buffer.sv
module dma_fifo_buffer
  import dma_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  parameter int THR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dirRx,
  input  logic              xferActive,
  input  logic              cpuWrEn,
  input  logic [WIDTH-1:0]  cpuWrData,
  input  logic              cpuRdEn,
  output logic [WIDTH-1:0]  cpuRdData,
  output logic              underrunPulse,
  input  logic              cardPushEn,
  input  logic [WIDTH-1:0]  cardPushData,
  input  logic              cardPopEn,
  output logic [WIDTH-1:0]  cardPopData,
  input  logic              cfgWr,
  input  logic [THR_W-1:0]  cfgAfLevel,
  input  logic [THR_W-1:0]  cfgAeLevel,
  input  logic              cfgRxDmaEn,
  input  logic              cfgTxDmaEn,
  output logic              rxDmaReq,
  output logic              txDmaReq,
  output logic              afFlag,
  output logic              aeFlag
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  fifoStrobe_t      strb;
  logic [CNT_W-1:0] level;
  logic [WIDTH-1:0] headData;

  dma_fifo_ctrl #(.DEPTH(DEPTH), .THR_W(THR_W)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .dirRx         (dirRx),
    .xferActive    (xferActive),
    .cpuWrEn       (cpuWrEn),
    .cpuRdEn       (cpuRdEn),
    .cardPushEn    (cardPushEn),
    .cardPopEn     (cardPopEn),
    .cfgWr         (cfgWr),
    .cfgAfLevel    (cfgAfLevel),
    .cfgAeLevel    (cfgAeLevel),
    .cfgRxDmaEn    (cfgRxDmaEn),
    .cfgTxDmaEn    (cfgTxDmaEn),
    .level         (level),
    .strb          (strb),
    .underrunPulse (underrunPulse),
    .rxDmaReq      (rxDmaReq),
    .txDmaReq      (txDmaReq),
    .afFlag        (afFlag),
    .aeFlag        (aeFlag)
  );

  dma_fifo_dp #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .cpuWrData    (cpuWrData),
    .cardPushData (cardPushData),
    .headData     (headData),
    .level        (level)
  );

  assign cpuRdData   = headData;
  assign cardPopData = headData;

endmodule

// File: tb/dma_fifo_buffer_bench.sv
module dma_fifo_buffer_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, dirRx, xferActive;
  logic        cpuWrEn, cpuRdEn, cardPushEn, cardPopEn;
  logic [15:0] cpuWrData, cardPushData;
  logic [15:0] cpuRdData, cardPopData;
  logic        underrunPulse;
  logic        cfgWr, cfgRxDmaEn, cfgTxDmaEn;
  logic [4:0]  cfgAfLevel, cfgAeLevel;
  logic        rxDmaReq, txDmaReq, afFlag, aeFlag;

  dma_fifo_buffer u_dma_fifo_buffer (
    .clk(clk), .rstN(rstN), .dirRx(dirRx), .xferActive(xferActive),
    .cpuWrEn(cpuWrEn), .cpuWrData(cpuWrData), .cpuRdEn(cpuRdEn),
    .cpuRdData(cpuRdData), .underrunPulse(underrunPulse),
    .cardPushEn(cardPushEn), .cardPushData(cardPushData),
    .cardPopEn(cardPopEn), .cardPopData(cardPopData),
    .cfgWr(cfgWr), .cfgAfLevel(cfgAfLevel), .cfgAeLevel(cfgAeLevel),
    .cfgRxDmaEn(cfgRxDmaEn), .cfgTxDmaEn(cfgTxDmaEn),
    .rxDmaReq(rxDmaReq), .txDmaReq(txDmaReq), .afFlag(afFlag), .aeFlag(aeFlag)
  );

  // Bench model of the requirements.
  logic [15:0] bMem [32];
  int bStart = 0;
  int bLen   = 0;
  int mAf    = 31;
  int mAe    = 0;
  bit mRx    = 1'b0;
  bit mTx    = 1'b0;
  int nChk   = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkOuts(string tag, bit expU);
    bit idle, rxHit, txHit;
    idle  = !xferActive && (bLen == 0);
    rxHit = dirRx  && (bLen > mAf);
    txHit = !dirRx && (bLen < mAe);
    chk(tag, "rxDmaReq", 32'(rxDmaReq), 32'(rxHit && mRx));
    chk(tag, "afFlag",   32'(afFlag),   32'(rxHit && !mRx && !idle));
    chk(tag, "txDmaReq", 32'(txDmaReq), 32'(txHit && mTx));
    chk(tag, "aeFlag",   32'(aeFlag),   32'(txHit && !mTx && !idle));
    chk(tag, "underrun", 32'(underrunPulse), 32'(expU));
  endtask

  // One clock with the given strobes; entered and left just after a falling edge.
  task automatic step(string tag, bit cw, logic [15:0] cwd, bit cr,
                      bit kp, logic [15:0] kpd, bit kc);
    bit pushOk, popReq, popOk, expU;
    cpuWrEn = cw; cpuWrData = cwd; cpuRdEn = cr;
    cardPushEn = kp; cardPushData = kpd; cardPopEn = kc;
    #1;
    pushOk = (dirRx ? kp : cw) && (bLen < 32);
    popReq = dirRx ? cr : kc;
    popOk  = popReq && (bLen > 0);
    expU   = dirRx && cr && (bLen == 0);
    if (popReq) begin
      chk(tag, "read data", 32'(dirRx ? cpuRdData : cardPopData), 32'(bMem[bStart]));
    end
    @(posedge clk);
    #2;
    cpuWrEn = 1'b0; cpuRdEn = 1'b0; cardPushEn = 1'b0; cardPopEn = 1'b0;
    if (pushOk) bMem[(bStart + bLen) % 32] = dirRx ? kpd : cwd;
    if (popOk)  bStart = (bStart + 1) % 32;
    bLen = bLen + int'(pushOk) - int'(popOk);
    checkOuts(tag, expU);
    @(negedge clk);
  endtask

  task automatic doPush(string tag, logic [15:0] d);
    if (dirRx) step(tag, 1'b0, 16'h0, 1'b0, 1'b1, d, 1'b0);
    else       step(tag, 1'b1, d, 1'b0, 1'b0, 16'h0, 1'b0);
  endtask

  task automatic doPop(string tag);
    if (dirRx) step(tag, 1'b0, 16'h0, 1'b1, 1'b0, 16'h0, 1'b0);
    else       step(tag, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 1'b1);
  endtask

  task automatic cfgLoad(string tag, int af, int ae, bit rxE, bit txE);
    cfgAfLevel = 5'(af); cfgAeLevel = 5'(ae);
    cfgRxDmaEn = rxE; cfgTxDmaEn = txE; cfgWr = 1'b1;
    #1;
    checkOuts(tag, underrunPulse);   // old configuration still governs (R10)
    @(posedge clk);
    #2;
    cfgWr = 1'b0;
    mAf = af; mAe = ae; mRx = rxE; mTx = txE;
    checkOuts(tag, 1'b0);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nChk, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; dirRx = 1'b0; xferActive = 1'b0;
    cpuWrEn = 1'b0; cpuRdEn = 1'b0; cardPushEn = 1'b0; cardPopEn = 1'b0;
    cpuWrData = '0; cardPushData = '0;
    cfgWr = 1'b0; cfgAfLevel = '0; cfgAeLevel = '0; cfgRxDmaEn = 1'b0; cfgTxDmaEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state at the ports.
    checkOuts("R1", 1'b0);

    // R1: reset almost-full threshold is 31 (flag only at level 32), DMA off.
    xferActive = 1'b1;
    dirRx = 1'b1;
    for (int k = 0; k < 32; k++) doPush("R1", 16'h1000 + 16'(k));
    for (int k = 0; k < 32; k++) doPop("R2");
    dirRx = 1'b0;
    #1;
    checkOuts("R1", 1'b0);  // almost-empty reset 0: never below

    // R6/R7/R8/R2/R4: sweep every threshold, both directions, both DMA modes.
    for (int d = 0; d < 2; d++) begin
      for (int e = 0; e < 2; e++) begin
        for (int t = 0; t < 32; t++) begin
          string tg;
          tg = (d != 0) ? "R6" : "R7";
          dirRx = (d != 0);
          cfgLoad("R10", t, t, e != 0, e != 0);
          doPush("R2", 16'hBEEF ^ 16'(t));   // advance read position by one
          doPop("R2");
          for (int k = 0; k < 33; k++)
            doPush((k == 32) ? "R4" : tg, 16'((d << 14) ^ (e << 13) ^ (t << 6) ^ k ^ 16'h2A00));
          for (int k = 0; k < 33; k++)
            doPop((k == 32) ? "R5" : "R2");
        end
      end
    end

    // R8: condition false in each direction, DMA enabled.
    cfgLoad("R8", 3, 2, 1'b1, 1'b1);
    dirRx = 1'b1;
    doPush("R8", 16'h0101); doPush("R8", 16'h0202);
    dirRx = 1'b0;
    #1; checkOuts("R8", 1'b0);    // level 2 not below 2, receive side idle
    dirRx = 1'b1;
    doPop("R2"); doPop("R2");

    // R3: strobes of the inactive side are ignored.
    step("R3", 1'b1, 16'hDEAD, 1'b0, 1'b0, 16'h0, 1'b0);   // cpu write in receive
    step("R3", 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 1'b1);      // card pop in receive
    doPush("R3", 16'h1111);
    doPop("R3");
    dirRx = 1'b0;
    step("R3", 1'b0, 16'h0, 1'b0, 1'b1, 16'hDEAD, 1'b0);   // card push in transmit
    step("R3", 1'b0, 16'h0, 1'b1, 1'b0, 16'h0, 1'b0);      // cpu read in transmit: no underrun
    doPush("R3", 16'h2222);
    step("R3", 1'b0, 16'h0, 1'b1, 1'b0, 16'h0, 1'b0);      // level must stay 1
    doPop("R3");

    // R5: underrun in receive, one-cycle pulse, head unchanged.
    dirRx = 1'b1;
    doPop("R5");
    step("R5", 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 1'b0);      // pulse gone
    doPop("R5"); doPop("R5");                               // back-to-back
    step("R5", 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 1'b1);      // card pop on empty ignored

    // R11: push and pop together, including on empty and at full.
    for (int k = 0; k < 3; k++) doPush("R11", 16'h3300 + 16'(k));
    for (int k = 0; k < 6; k++)
      step("R11", 1'b0, 16'h0, 1'b1, 1'b1, 16'h4400 + 16'(k), 1'b0);
    while (bLen < 32) doPush("R11", 16'h5500 + 16'(bLen));
    step("R4", 1'b0, 16'h0, 1'b1, 1'b1, 16'hF00D, 1'b0);   // push at full dropped
    while (bLen > 0) doPop("R2");
    step("R11", 1'b0, 16'h0, 1'b1, 1'b1, 16'h6600, 1'b0);  // empty: push only
    doPop("R11");

    // R9: idle and empty clears flags, DMA request still follows threshold.
    dirRx = 1'b0;
    cfgLoad("R9", 31, 5, 1'b0, 1'b0);
    xferActive = 1'b0;
    #1; checkOuts("R9", 1'b0);
    xferActive = 1'b1;
    #1; checkOuts("R9", 1'b0);
    cfgLoad("R9", 31, 5, 1'b0, 1'b1);
    xferActive = 1'b0;
    #1; checkOuts("R9", 1'b0);
    doPush("R9", 16'h7777);
    doPop("R9");

    // R10: configuration inputs without the load strobe have no effect.
    cfgAfLevel = 5'd0; cfgAeLevel = 5'd31; cfgTxDmaEn = 1'b0; cfgRxDmaEn = 1'b1;
    xferActive = 1'b1;
    step("R10", 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 1'b0);
    doPush("R10", 16'h8888);
    cfgLoad("R10", 0, 31, 1'b1, 1'b0);
    dirRx = 1'b1;
    #1; checkOuts("R10", 1'b0);
    doPop("R10");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChk, nFail);
    $finish;
  end

endmodule